// File: doc/BRIEF.md
# CRC Input Width and Byte-Count Sequencer

This block sits between a word-wide input FIFO and a CRC engine. It pops words from the FIFO while a job is active. For each word it works out how many bits are valid and registers the word and that bit count towards the engine, together with a one-cycle strobe. A programmed byte total sets the length of the job. The block counts down the bytes still owed and raises two flags: one when all requested bytes have left the FIFO, and one when the engine has taken the last word.

The valid width of a word comes from one of three sources. By default it comes from the word's byte enables. A register-width mode uses a fixed programmed value. A count mode uses whichever is smaller: the byte enables or the bytes still owed. A soft reset asks the FIFO to flush and returns the sequencer to idle.

Top module: `crc_width_seq`

## Requirements
- R1: While reset is applied and after it is released with no other stimulus, `fifo_pop`, `eng_strobe`, `bytes_done` and `calc_done` are 0.
- R2: With both mode selects low, a popped word's valid bit count is 8 times the number of set bits in `fifo_be`, where bit i of `fifo_be` marks byte i (bits 8i+7..8i) of `fifo_data`.
- R3: With `mode_reg` high and `mode_cnt` low, the bit count is `width_reg`, where 0 stands for the full word width, whatever `fifo_be` holds. The bytes consumed are that count divided by 8, rounded up.
- R4: With `mode_cnt` high, the bytes consumed are the smaller of the byte-enable byte count and the bytes still owed, and the bit count is 8 times that. This holds whatever `mode_reg` says.
- R5: A `cnt_load` with a nonzero `cnt_value` starts a job from idle or from done, clearing both flags. A `cnt_load` with zero has no effect.
- R6: `fifo_pop` is high only while a job runs, `fifo_empty` is low and bytes are still owed. The cycle after a pop, `eng_strobe` is high with the popped data and its bit count.
- R7: The bytes owed drop by the bytes consumed per popped word and stop at zero. `bytes_done` is high from the cycle after the pop that brings them to zero until the job is cleared.
- R8: `calc_done` rises the cycle after the last `eng_strobe`. It stays high until a soft reset or a new nonzero load.
- R9: `fifo_flush` follows `soft_rst` in the same cycle. The cycle after `soft_rst`, the block is idle with both flags low, even if `cnt_load` was high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous return to idle with FIFO flush |
| cnt_load | input | 1 | Load strobe for the byte total |
| cnt_value | input | CNT_W (16) | Byte total of the job |
| width_reg | input | WREG_W (5) | Fixed bit width for register mode, 0 = full word |
| mode_reg | input | 1 | Select register-width mode |
| mode_cnt | input | 1 | Select count mode (wins over mode_reg) |
| fifo_empty | input | 1 | FIFO has no word |
| fifo_data | input | DATA_W (32) | FIFO head word |
| fifo_be | input | DATA_W/8 (4) | Byte enables of the head word |
| fifo_pop | output | 1 | Pop the head word |
| fifo_flush | output | 1 | Empty the FIFO |
| eng_data | output | DATA_W (32) | Word towards the CRC engine |
| eng_nbits | output | NB_W (6) | Valid bits of eng_data |
| eng_strobe | output | 1 | eng_data and eng_nbits are new this cycle |
| bytes_done | output | 1 | All requested bytes read from the FIFO |
| calc_done | output | 1 | Engine has received the last word |

## Verification
The bench builds the block with its defaults: a 32-bit word with four byte lanes, a 16-bit byte total and a 5-bit width register. With four lanes, every width source can be tested with partial words. A byte total that is not a multiple of four lets count mode clip a final word. A total smaller than a full word forces the remaining-byte counter to saturate in byte-enable mode. Register widths that are not multiples of eight check the rounding of bytes consumed.

// File: rtl/crc_seq_pkg.sv
package crc_seq_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_RUN  = 2'd1,
      SEQ_DONE = 2'd2
   } seq_state_t;
endpackage

// File: rtl/crc_seq_width.sv
module crc_seq_width #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16,
   localparam int BYTES  = DATA_W / 8,
   localparam int BC_W   = $clog2(BYTES + 1),
   localparam int NB_W   = $clog2(DATA_W + 1),
   localparam int WREG_W = $clog2(DATA_W)
) (
   input  logic [BYTES-1:0]  be,
   input  logic [WREG_W-1:0] wreg,
   input  logic [CNT_W-1:0]  owed,
   input  logic              sel_reg,
   input  logic              sel_cnt,
   output logic [NB_W-1:0]   nbits,
   output logic [BC_W-1:0]   nbytes
);
   logic [BC_W-1:0] lane_sum [BYTES+1];
   logic [BC_W-1:0] be_bytes;
   logic [BC_W-1:0] owed_clip;
   logic [BC_W-1:0] cnt_bytes;
   logic [NB_W:0]   reg_bits;

   assign lane_sum[0] = '0;
   for (genvar g = 0; g < BYTES; g++) begin : g_lane
      assign lane_sum[g+1] = lane_sum[g] + BC_W'(be[g]);
   end
   assign be_bytes = lane_sum[BYTES];

   assign owed_clip = (owed > CNT_W'(BYTES)) ? BC_W'(BYTES) : BC_W'(owed);
   assign cnt_bytes = (be_bytes < owed_clip) ? be_bytes : owed_clip;
   assign reg_bits  = (wreg == '0) ? (NB_W+1)'(DATA_W) : (NB_W+1)'(wreg);

   always_comb begin
      if (sel_cnt) begin
         nbytes = cnt_bytes;
         nbits  = NB_W'(cnt_bytes) << 3;
      end else if (sel_reg) begin
         nbits  = NB_W'(reg_bits);
         nbytes = BC_W'((reg_bits + (NB_W+1)'(7)) >> 3);
      end else begin
         nbytes = be_bytes;
         nbits  = NB_W'(be_bytes) << 3;
      end
   end
endmodule

// File: rtl/crc_seq_remain.sv
module crc_seq_remain #(
   parameter int CNT_W = 16,
   parameter int BC_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             consume,
   input  logic [BC_W-1:0]  nbytes,
   output logic [CNT_W-1:0] owed
);
   logic [CNT_W-1:0] take;
   assign take = CNT_W'(nbytes);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          owed <= '0;
      else if (clear)      owed <= '0;
      else if (load)       owed <= load_val;
      else if (consume)    owed <= (owed > take) ? owed - take : '0;
   end
endmodule

// File: rtl/crc_width_seq.sv
module crc_width_seq #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16,
   localparam int BYTES  = DATA_W / 8,
   localparam int BC_W   = $clog2(BYTES + 1),
   localparam int NB_W   = $clog2(DATA_W + 1),
   localparam int WREG_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              cnt_load,
   input  logic [CNT_W-1:0]  cnt_value,
   input  logic [WREG_W-1:0] width_reg,
   input  logic              mode_reg,
   input  logic              mode_cnt,
   input  logic              fifo_empty,
   input  logic [DATA_W-1:0] fifo_data,
   input  logic [BYTES-1:0]  fifo_be,
   output logic              fifo_pop,
   output logic              fifo_flush,
   output logic [DATA_W-1:0] eng_data,
   output logic [NB_W-1:0]   eng_nbits,
   output logic              eng_strobe,
   output logic              bytes_done,
   output logic              calc_done
);
   import crc_seq_pkg::*;

   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("crc_width_seq: DATA_W must be a nonzero multiple of 8");
   end
   if (CNT_W < BC_W) begin : g_bad_cnt
      $error("crc_width_seq: CNT_W too narrow for one word of bytes");
   end

   seq_state_t       state;
   logic [CNT_W-1:0] owed;
   logic [NB_W-1:0]  w_bits;
   logic [BC_W-1:0]  w_bytes;
   logic             start;

   assign start      = cnt_load && (cnt_value != '0) && (state != SEQ_RUN) && !soft_rst;
   assign fifo_pop   = (state == SEQ_RUN) && !fifo_empty && (owed != '0) && !soft_rst;
   assign fifo_flush = soft_rst;
   assign bytes_done = (state != SEQ_IDLE) && (owed == '0);
   assign calc_done  = (state == SEQ_DONE);

   crc_seq_width #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_width (
      .be      (fifo_be),
      .wreg    (width_reg),
      .owed    (owed),
      .sel_reg (mode_reg),
      .sel_cnt (mode_cnt),
      .nbits   (w_bits),
      .nbytes  (w_bytes)
   );

   crc_seq_remain #(.CNT_W(CNT_W), .BC_W(BC_W)) u_remain (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (soft_rst),
      .load     (start),
      .load_val (cnt_value),
      .consume  (fifo_pop),
      .nbytes   (w_bytes),
      .owed     (owed)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= SEQ_IDLE;
         eng_strobe <= 1'b0;
         eng_data   <= '0;
         eng_nbits  <= '0;
      end else if (soft_rst) begin
         state      <= SEQ_IDLE;
         eng_strobe <= 1'b0;
      end else begin
         eng_strobe <= fifo_pop;
         if (fifo_pop) begin
            eng_data  <= fifo_data;
            eng_nbits <= w_bits;
         end
         unique case (state)
            SEQ_IDLE: if (start) state <= SEQ_RUN;
            SEQ_RUN:  if (owed == '0 && eng_strobe) state <= SEQ_DONE;
            SEQ_DONE: if (start) state <= SEQ_RUN;
            default:  state <= SEQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/crc_width_seq_chk.sv
module crc_width_seq_chk #(
   parameter int DATA_W = 32,
   localparam int NB_W = $clog2(DATA_W + 1)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            soft_rst,
   input logic            fifo_empty,
   input logic            fifo_pop,
   input logic            fifo_flush,
   input logic [NB_W-1:0] eng_nbits,
   input logic            eng_strobe,
   input logic            bytes_done,
   input logic            calc_done
);
   a_r6_pop_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> !fifo_empty);
   a_r6_strobe_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop && !soft_rst |=> eng_strobe);
   a_r6_strobe_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      eng_strobe |-> $past(fifo_pop));
   a_r2_nbits_bound: assert property (@(posedge clk) disable iff (!rst_n)
      eng_strobe |-> (eng_nbits <= NB_W'(DATA_W)));
   a_r8_calc_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(calc_done) |-> $past(eng_strobe));
   a_r7_calc_implies_bytes: assert property (@(posedge clk) disable iff (!rst_n)
      calc_done |-> bytes_done);
   a_r9_soft_clears: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !calc_done && !bytes_done && !eng_strobe);
   a_r9_flush_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_flush == soft_rst);
endmodule

bind crc_width_seq crc_width_seq_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .soft_rst   (soft_rst),
   .fifo_empty (fifo_empty),
   .fifo_pop   (fifo_pop),
   .fifo_flush (fifo_flush),
   .eng_nbits  (eng_nbits),
   .eng_strobe (eng_strobe),
   .bytes_done (bytes_done),
   .calc_done  (calc_done)
);

// File: tb/crc_width_seq_tb_top.sv
`timescale 1ns/1ps
module crc_width_seq_tb_top;
   localparam int DATA_W = 32;
   localparam int CNT_W  = 16;
   localparam int BYTES  = DATA_W / 8;
   localparam int NB_W   = $clog2(DATA_W + 1);
   localparam int WREG_W = $clog2(DATA_W);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic soft_rst = 1'b0, cnt_load = 1'b0, mode_reg = 1'b0, mode_cnt = 1'b0;
   logic fifo_empty = 1'b1;
   logic [CNT_W-1:0]  cnt_value = '0;
   logic [WREG_W-1:0] width_reg = '0;
   logic [DATA_W-1:0] fifo_data = '0;
   logic [BYTES-1:0]  fifo_be = '0;
   logic fifo_pop, fifo_flush, eng_strobe, bytes_done, calc_done;
   logic [DATA_W-1:0] eng_data;
   logic [NB_W-1:0]   eng_nbits;

   int checks = 0;
   int errors = 0;
   bit ended = 1'b0;

   always #4 clk = ~clk;

   crc_width_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cnt_load(cnt_load),
      .cnt_value(cnt_value), .width_reg(width_reg), .mode_reg(mode_reg),
      .mode_cnt(mode_cnt), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
      .fifo_be(fifo_be), .fifo_pop(fifo_pop), .fifo_flush(fifo_flush),
      .eng_data(eng_data), .eng_nbits(eng_nbits), .eng_strobe(eng_strobe),
      .bytes_done(bytes_done), .calc_done(calc_done)
   );

   // {cnt[33:18], be[17:14], wreg[13:9], mode_reg[8], mode_cnt[7], nbits[6:1], bytes_done[0]}
   localparam logic [33:0] VEC [10] = '{
      {16'd4, 4'b1111, 5'd0,  1'b0, 1'b0, 6'd32, 1'b1},  // R2 full word
      {16'd8, 4'b0011, 5'd0,  1'b0, 1'b0, 6'd16, 1'b0},  // R2 half word, bytes left
      {16'd1, 4'b0001, 5'd0,  1'b0, 1'b0, 6'd8,  1'b1},  // R2 one lane
      {16'd2, 4'b1111, 5'd0,  1'b0, 1'b0, 6'd32, 1'b1},  // R7 saturation at zero
      {16'd8, 4'b1111, 5'd12, 1'b1, 1'b0, 6'd12, 1'b0},  // R3 12 bits -> 2 bytes, 6 left
      {16'd4, 4'b0001, 5'd0,  1'b1, 1'b0, 6'd32, 1'b1},  // R3 zero means full, be ignored
      {16'd2, 4'b0000, 5'd9,  1'b1, 1'b0, 6'd9,  1'b1},  // R3 9 bits -> 2 bytes
      {16'd3, 4'b1111, 5'd0,  1'b0, 1'b1, 6'd24, 1'b1},  // R4 clipped by owed
      {16'd5, 4'b0011, 5'd0,  1'b0, 1'b1, 6'd16, 1'b0},  // R4 clipped by be
      {16'd2, 4'b0111, 5'd5,  1'b1, 1'b1, 6'd16, 1'b1}   // R4 overrides register mode
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   task automatic soft_pulse();
      @(negedge clk) soft_rst = 1'b1;
      @(negedge clk) soft_rst = 1'b0;
   endtask

   task automatic load(input int n);
      @(negedge clk) begin cnt_load = 1'b1; cnt_value = CNT_W'(n); end
      @(negedge clk) cnt_load = 1'b0;
   endtask

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1 pop in reset", int'(fifo_pop), 0);
      check("R1 calc_done in reset", int'(calc_done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 strobe after reset", int'(eng_strobe), 0);
      check("R1 bytes_done after reset", int'(bytes_done), 0);

      // Vector table: one word per job
      for (int i = 0; i < 10; i++) begin
         soft_pulse();
         mode_reg  = VEC[i][8];
         mode_cnt  = VEC[i][7];
         width_reg = VEC[i][13:9];
         load(int'(VEC[i][33:18]));
         fifo_empty = 1'b0;
         fifo_be    = VEC[i][17:14];
         fifo_data  = DATA_W'(32'hA5C3_0000 + i);
         @(negedge clk) fifo_empty = 1'b1;
         check("R6 strobe after pop", int'(eng_strobe), 1);
         check("R6 data passed", int'(eng_data == DATA_W'(32'hA5C3_0000 + i)), 1);
         check("R2/R3/R4 nbits", int'(eng_nbits), int'(VEC[i][6:1]));
         check("R7 bytes_done", int'(bytes_done), int'(VEC[i][0]));
         @(negedge clk);
         check("R8 calc_done", int'(calc_done), int'(VEC[i][0]));
         check("R6 single strobe", int'(eng_strobe), 0);
      end

      // R5 zero load ignored
      mode_reg = 1'b0; mode_cnt = 1'b0;
      soft_pulse();
      load(0);
      fifo_empty = 1'b0; fifo_be = 4'b1111;
      #1 check("R5 zero load no pop", int'(fifo_pop), 0);
      @(negedge clk) fifo_empty = 1'b1;
      check("R5 zero load no strobe", int'(eng_strobe), 0);
      check("R5 zero load no bytes_done", int'(bytes_done), 0);

      // R6 no pop while FIFO empty
      load(4);
      #1 check("R6 no pop when empty", int'(fifo_pop), 0);
      @(negedge clk);
      check("R6 no strobe when empty", int'(eng_strobe), 0);
      check("R7 owed kept when empty", int'(bytes_done), 0);

      // Multi-word count-mode job: 10 bytes -> 32, 32, 16
      soft_pulse();
      mode_cnt = 1'b1;
      load(10);
      fifo_empty = 1'b0; fifo_be = 4'b1111;
      @(negedge clk);
      check("R4 word1 nbits", int'(eng_nbits), 32);
      check("R7 word1 not done", int'(bytes_done), 0);
      @(negedge clk);
      check("R4 word2 nbits", int'(eng_nbits), 32);
      @(negedge clk);
      check("R4 last word clipped", int'(eng_nbits), 16);
      check("R7 bytes_done at end", int'(bytes_done), 1);
      check("R8 calc_done not yet", int'(calc_done), 0);
      #1 check("R6 no pop once owed zero", int'(fifo_pop), 0);
      @(negedge clk);
      check("R8 calc_done after last strobe", int'(calc_done), 1);
      check("R6 no extra strobe", int'(eng_strobe), 0);
      fifo_empty = 1'b1;
      @(negedge clk);
      check("R8 calc_done held", int'(calc_done), 1);

      // R5 restart from DONE
      load(4);
      check("R5 restart clears calc_done", int'(calc_done), 0);
      check("R5 restart clears bytes_done", int'(bytes_done), 0);
      fifo_empty = 1'b0;
      @(negedge clk) fifo_empty = 1'b1;
      check("R5 restart job word", int'(eng_nbits), 32);
      @(negedge clk);
      check("R8 restart job done", int'(calc_done), 1);

      // R9 soft reset with simultaneous load
      @(negedge clk) begin soft_rst = 1'b1; cnt_load = 1'b1; cnt_value = 16'd8; end
      #1 check("R9 flush follows soft reset", int'(fifo_flush), 1);
      @(negedge clk) begin soft_rst = 1'b0; cnt_load = 1'b0; end
      check("R9 calc_done cleared", int'(calc_done), 0);
      check("R9 bytes_done cleared", int'(bytes_done), 0);
      #1 check("R9 flush released", int'(fifo_flush), 0);
      fifo_empty = 1'b0;
      #1 check("R9 idle, load ignored", int'(fifo_pop), 0);
      @(negedge clk) fifo_empty = 1'b1;

      finish_run();
   end
endmodule